// File: doc/BRIEF.md
# Clock-Select Setup Register with Core Restart Control

This block is the setup register of a serial network controller, written and read by the host CPU. It holds four fields: a fast CPU read-timing enable, a two-bit core clock select, an enhanced-functions enable and a skip-line-idle flag for RAM initialization. Each field drives a decoded control output. The fast-read control is also gated by an external bus-timing strap pin and by a multiplexed-bus indication.

The clock-select field also drives a small run/halt controller for the protocol core. When software changes the clock select, the core stops at once and a clock-multiplier model powers up. A counter stands in for the analog lock time. The core stays halted until the multiplier is locked and software has written the restart command value 0x18 to the command register. The clock select may change only once per hardware reset. A later attempt to change it is dropped and sets a sticky error flag.

Top module: `clksel_setup_reg`

## Requirements
- R1: After reset, `reg_rdata` reads 0x00, `core_run_o` is 1, `pll_en_o` is 0, `lock_cnt_o` is 0, `pll_locked_o` is 0 and `sel_err_o` is 0.
- R2: Bit 7 of the register is the fast-read enable and reads back as written. `fast_read_o` is 1 only when bit 7 is 1, `bus_strap_i` is 1 and `bus_muxed_i` is 0.
- R3: Bits 5:4 of the register are the clock select, with 00 = base clock, 01 = double and 11 = quadruple. A write whose bits 5:4 are 10 leaves the stored select unchanged, does not halt the core and sets no error.
- R4: The first write that changes the clock select to another allowed code stores the new code. In the cycle after that write, `core_run_o` is 0 and `pll_en_o` is 1. `pll_en_o` then stays 1 until reset.
- R5: `lock_cnt_o` is 0 in the cycle after the select change and rises by one per cycle. It saturates at LOCK_CYCLES. `pll_locked_o` is 1 exactly when the count has reached LOCK_CYCLES, which is LOCK_CYCLES cycles after the change.
- R6: While the core is halted and the multiplier is locked, a command write of 0x18 sets `core_run_o` to 1 in the next cycle. Any other command value has no effect. A command write of 0x18 has no effect while the core runs.
- R7: A 0x18 command written while the core is halted and before lock is kept. The core then resumes in the cycle after `pll_locked_o` rises, with no further command.
- R8: After the one allowed change, a write that tries to change the clock select again is ignored and sets `sel_err_o` to 1. `sel_err_o` stays 1 until reset. A write that repeats the current select sets no error.
- R9: Bit 3 is the enhanced-functions enable (`enh_func_o`) and bit 2 is the skip-line-idle flag (`sync_skip_o`). Both read back as written and can be written at any time without halting the core.
- R10: Bits 6, 1 and 0 of the register read as 0, whatever value is written to them.
- R11: A 0x18 command written in the same cycle as an accepted clock-select change is discarded. The core stays halted after lock until a new 0x18 command arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| reg_wr | input | 1 | Setup register write strobe |
| reg_wdata | input | 8 | Setup register write data |
| reg_rdata | output | 8 | Setup register read data |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 8 | Command register write data |
| bus_strap_i | input | 1 | External bus-timing strap |
| bus_muxed_i | input | 1 | 1 when the CPU bus is address/data multiplexed |
| core_run_o | output | 1 | Protocol core run enable |
| pll_en_o | output | 1 | Clock multiplier power enable |
| lock_cnt_o | output | CNT_W | Multiplier lock timer value |
| pll_locked_o | output | 1 | Multiplier lock indication |
| fast_read_o | output | 1 | Fast CPU read timing active |
| clk_sel_o | output | 2 | Selected core clock code |
| enh_func_o | output | 1 | Enhanced functions enabled |
| sync_skip_o | output | 1 | RAM init does not wait for an idle line |
| sel_err_o | output | 1 | Sticky flag for a refused second select change |

## Verification
Two events can fall on the same clock edge: a register write that changes the clock select and a command write of the restart value. The bench provokes this by raising both strobes together while the core is running. It then waits past lock with no further command. The collision is judged correct if the core is still halted after lock and resumes only after a fresh 0x18 command. A second corner case is also checked: a restart command written before lock, where the core must resume exactly one cycle after lock rises.

// File: rtl/clksel_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the clock-select setup register.
// Assumes an 8-bit register with the field positions fixed below.
package clksel_pkg;

    typedef enum logic [1:0] {
        SEL_BASE = 2'b00,
        SEL_X2   = 2'b01,
        SEL_RSVD = 2'b10,
        SEL_X4   = 2'b11
    } clk_sel_e;

    typedef enum logic [1:0] {
        CORE_RUNNING = 2'b00,
        CORE_HALTED  = 2'b01,
        CORE_ARMED   = 2'b10
    } core_state_e;

    typedef struct packed {
        logic     fast_rd_en;
        clk_sel_e clk_sel;
        logic     enh_func;
        logic     sync_skip;
    } setup_t;

    localparam int          BIT_FAST_RD = 7;
    localparam int          BIT_SEL_HI  = 5;
    localparam int          BIT_SEL_LO  = 4;
    localparam int          BIT_ENH     = 3;
    localparam int          BIT_SKIP    = 2;
    localparam logic [7:0]  RESTART_CMD = 8'h18;

endpackage

// File: rtl/clksel_setup_fields.sv
`timescale 1ns/1ps
// Module: setup field storage and one-shot clock-select change control.
// Stores the register fields, drops the reserved select code, allows one
// select change per reset and flags any later change attempt.
// Assumes writes are single-cycle strobes in the clk domain.
module clksel_setup_fields
    import clksel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output setup_t     cfg,
    output logic       sel_change,
    output logic       sel_err
);

    clk_sel_e req_sel;
    logic     sel_differs;
    logic     change_used;
    logic     unused_wbits;

    assign unused_wbits = ^{wdata[6], wdata[1:0]};

    // Decode the requested select and see whether it is a real, allowed change.
    always_comb begin
        req_sel     = clk_sel_e'(wdata[BIT_SEL_HI:BIT_SEL_LO]);
        sel_differs = wr_en && (req_sel != SEL_RSVD) && (req_sel != cfg.clk_sel);
        sel_change  = sel_differs && !change_used;
    end

    // Store the plain fields on every write, the select only on an accepted change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '{fast_rd_en: 1'b0, clk_sel: SEL_BASE, enh_func: 1'b0, sync_skip: 1'b0};
        end else if (wr_en) begin
            cfg.fast_rd_en <= wdata[BIT_FAST_RD];
            cfg.enh_func   <= wdata[BIT_ENH];
            cfg.sync_skip  <= wdata[BIT_SKIP];
            if (sel_change) begin
                cfg.clk_sel <= req_sel;
            end
        end
    end

    // Remember the single allowed change and latch the error on a refused one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            change_used <= 1'b0;
            sel_err     <= 1'b0;
        end else begin
            if (sel_change) begin
                change_used <= 1'b1;
            end
            if (sel_differs && change_used) begin
                sel_err <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/clksel_pll_model.sv
`timescale 1ns/1ps
// Module: behavioural stand-in for the clock-multiplier PLL.
// Powers up on a one-cycle request and counts LOCK_CYCLES cycles to lock.
// Assumes it powers up at most once per reset and never powers down.
module clksel_pll_model #(
    parameter int LOCK_CYCLES = 1000,
    parameter int CNT_W       = $clog2(LOCK_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             power_up,
    output logic             pll_en,
    output logic [CNT_W-1:0] lock_cnt,
    output logic             locked
);

    localparam logic [CNT_W-1:0] LOCK_VAL = CNT_W'(LOCK_CYCLES);

    // Hold the multiplier power enable once it is requested.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pll_en <= 1'b0;
        end else if (power_up) begin
            pll_en <= 1'b1;
        end
    end

    // Count lock time while powered, saturating at the lock value.
    always_ff @(posedge clk) begin
        if (!rst_n || !pll_en) begin
            lock_cnt <= '0;
        end else if (lock_cnt != LOCK_VAL) begin
            lock_cnt <= lock_cnt + CNT_W'(1);
        end
    end

    assign locked = pll_en && (lock_cnt == LOCK_VAL);

endmodule

// File: rtl/clksel_core_ctrl.sv
`timescale 1ns/1ps
// Module: run/halt control of the protocol core.
// Halts on a clock-select change and resumes after the restart command
// and multiplier lock. A restart command seen before lock is kept.
// Assumes the select change and lock inputs come from the same clk domain.
module clksel_core_ctrl
    import clksel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_change,
    input  logic       cmd_wr,
    input  logic [7:0] cmd_wdata,
    input  logic       locked,
    output logic       core_run
);

    core_state_e state_q, state_d;
    logic        restart_req;

    // Pick the next run/halt state from change, command and lock.
    always_comb begin
        restart_req = cmd_wr && (cmd_wdata == RESTART_CMD);
        state_d     = state_q;
        unique case (state_q)
            CORE_RUNNING: if (sel_change)  state_d = CORE_HALTED;
            CORE_HALTED:  if (restart_req) state_d = locked ? CORE_RUNNING : CORE_ARMED;
            CORE_ARMED:   if (locked)      state_d = CORE_RUNNING;
            default:                       state_d = CORE_HALTED;
        endcase
    end

    // Register the run/halt state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CORE_RUNNING;
        end else begin
            state_q <= state_d;
        end
    end

    assign core_run = (state_q == CORE_RUNNING);

endmodule

// File: rtl/clksel_setup_reg.sv
`timescale 1ns/1ps
// Module: top of the clock-select setup register with core restart.
// Joins field storage, the PLL lock model and core run control, and
// builds the read data and the decoded controls.
// Assumes one register and one command port, both single-cycle strobes.
module clksel_setup_reg
    import clksel_pkg::*;
#(
    parameter int LOCK_CYCLES = 1000,
    parameter int CNT_W       = $clog2(LOCK_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             cmd_wr,
    input  logic [7:0]       cmd_wdata,
    input  logic             bus_strap_i,
    input  logic             bus_muxed_i,
    output logic             core_run_o,
    output logic             pll_en_o,
    output logic [CNT_W-1:0] lock_cnt_o,
    output logic             pll_locked_o,
    output logic             fast_read_o,
    output logic [1:0]       clk_sel_o,
    output logic             enh_func_o,
    output logic             sync_skip_o,
    output logic             sel_err_o
);

    setup_t cfg;
    logic   sel_change;

    clksel_setup_fields u_fields (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .wdata      (reg_wdata),
        .cfg        (cfg),
        .sel_change (sel_change),
        .sel_err    (sel_err_o)
    );

    clksel_pll_model #(
        .LOCK_CYCLES (LOCK_CYCLES),
        .CNT_W       (CNT_W)
    ) u_pll (
        .clk      (clk),
        .rst_n    (rst_n),
        .power_up (sel_change),
        .pll_en   (pll_en_o),
        .lock_cnt (lock_cnt_o),
        .locked   (pll_locked_o)
    );

    clksel_core_ctrl u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_change(sel_change),
        .cmd_wr    (cmd_wr),
        .cmd_wdata (cmd_wdata),
        .locked    (pll_locked_o),
        .core_run  (core_run_o)
    );

    // Assemble read data; unused bit positions read as zero.
    always_comb begin
        reg_rdata                         = '0;
        reg_rdata[BIT_FAST_RD]            = cfg.fast_rd_en;
        reg_rdata[BIT_SEL_HI:BIT_SEL_LO]  = cfg.clk_sel;
        reg_rdata[BIT_ENH]                = cfg.enh_func;
        reg_rdata[BIT_SKIP]               = cfg.sync_skip;
    end

    // Decode the field controls seen by the rest of the controller.
    always_comb begin
        fast_read_o = cfg.fast_rd_en && bus_strap_i && !bus_muxed_i;
        clk_sel_o   = cfg.clk_sel;
        enh_func_o  = cfg.enh_func;
        sync_skip_o = cfg.sync_skip;
    end

endmodule

// File: rtl/clksel_setup_chk.sv
`timescale 1ns/1ps
// Module: assertion checker for clksel_setup_reg, attached by bind.
// Watches only top-level ports plus one change counter of its own.
module clksel_setup_chk #(
    parameter int LOCK_CYCLES = 1000,
    parameter int CNT_W       = $clog2(LOCK_CYCLES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fast_read_o,
    input logic             bus_strap_i,
    input logic             bus_muxed_i,
    input logic             core_run_o,
    input logic             pll_en_o,
    input logic             pll_locked_o,
    input logic             sel_err_o,
    input logic [1:0]       clk_sel_o,
    input logic [CNT_W-1:0] lock_cnt_o
);

    logic [1:0] prev_sel;
    logic [1:0] n_changes;

    // Count how often the visible clock select has moved since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_sel  <= 2'b00;
            n_changes <= 2'd0;
        end else begin
            prev_sel <= clk_sel_o;
            if ((clk_sel_o != prev_sel) && (n_changes != 2'd3)) begin
                n_changes <= n_changes + 2'd1;
            end
        end
    end

    AST_FAST_READ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        fast_read_o |-> (bus_strap_i && !bus_muxed_i));                 // R2
    AST_NO_RESERVED_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        clk_sel_o != 2'b10);                                             // R3
    AST_HALT_WITH_PLL_UP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_en_o) |-> !core_run_o);                                // R4
    AST_PLL_STAYS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        pll_en_o |=> pll_en_o);                                          // R4
    AST_LOCK_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        lock_cnt_o <= CNT_W'(LOCK_CYCLES));                              // R5
    AST_RESUME_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_run_o) |-> pll_locked_o);                             // R6
    AST_SEL_CHANGED_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        n_changes <= 2'd1);                                              // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        sel_err_o |=> sel_err_o);                                        // R8

endmodule

bind clksel_setup_reg clksel_setup_chk #(
    .LOCK_CYCLES (LOCK_CYCLES),
    .CNT_W       (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fast_read_o  (fast_read_o),
    .bus_strap_i  (bus_strap_i),
    .bus_muxed_i  (bus_muxed_i),
    .core_run_o   (core_run_o),
    .pll_en_o     (pll_en_o),
    .pll_locked_o (pll_locked_o),
    .sel_err_o    (sel_err_o),
    .clk_sel_o    (clk_sel_o),
    .lock_cnt_o   (lock_cnt_o)
);

// File: tb/clksel_setup_reg_tb.sv
`timescale 1ns/1ps
// Bench: vector table for the plain fields, then directed select/restart tests.
module clksel_setup_reg_tb;

    localparam int LOCK = 12;
    localparam int CW   = $clog2(LOCK + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          cmd_wr = 1'b0;
    logic [7:0]    cmd_wdata = '0;
    logic          bus_strap_i = 1'b0;
    logic          bus_muxed_i = 1'b0;
    logic          core_run_o, pll_en_o, pll_locked_o, fast_read_o;
    logic          enh_func_o, sync_skip_o, sel_err_o;
    logic [1:0]    clk_sel_o;
    logic [CW-1:0] lock_cnt_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    clksel_setup_reg #(.LOCK_CYCLES(LOCK)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .bus_strap_i(bus_strap_i), .bus_muxed_i(bus_muxed_i),
        .core_run_o(core_run_o), .pll_en_o(pll_en_o), .lock_cnt_o(lock_cnt_o),
        .pll_locked_o(pll_locked_o), .fast_read_o(fast_read_o),
        .clk_sel_o(clk_sel_o), .enh_func_o(enh_func_o),
        .sync_skip_o(sync_skip_o), .sel_err_o(sel_err_o)
    );

    // Vector: {wdata[8], strap, muxed, exp_rdata[8], exp_fast}; select bits stay 00.
    localparam logic [18:0] VEC [8] = '{
        {8'h80, 1'b1, 1'b0, 8'h80, 1'b1},
        {8'h80, 1'b0, 1'b0, 8'h80, 1'b0},
        {8'h80, 1'b1, 1'b1, 8'h80, 1'b0},
        {8'h00, 1'b1, 1'b0, 8'h00, 1'b0},
        {8'h0C, 1'b1, 1'b0, 8'h0C, 1'b0},
        {8'h43, 1'b1, 1'b0, 8'h00, 1'b0},
        {8'hCF, 1'b1, 1'b0, 8'h8C, 1'b1},
        {8'h84, 1'b0, 1'b1, 8'h84, 1'b0}
    };

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Drive strobes at a falling edge, return at the next falling edge (one posedge later).
    task automatic drive(input bit rw, input logic [7:0] rd, input bit cw, input logic [7:0] cd);
        reg_wr = rw; reg_wdata = rd; cmd_wr = cw; cmd_wdata = cd;
        @(negedge clk);
        reg_wr = 1'b0; cmd_wr = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic reset_checks();
        chk("R1", "rdata",    32'(reg_rdata),    32'h00);
        chk("R1", "core_run", 32'(core_run_o),   32'd1);
        chk("R1", "pll_en",   32'(pll_en_o),     32'd0);
        chk("R1", "lock_cnt", 32'(lock_cnt_o),   32'd0);
        chk("R1", "locked",   32'(pll_locked_o), 32'd0);
        chk("R1", "sel_err",  32'(sel_err_o),    32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        reset_checks();

        // R2, R9, R10: plain field writes from the table
        for (int i = 0; i < 8; i++) begin
            bus_strap_i = VEC[i][10];
            bus_muxed_i = VEC[i][9];
            drive(1'b1, VEC[i][18:11], 1'b0, 8'h00);
            chk("R2/R10 vec", "rdata", 32'(reg_rdata), 32'(VEC[i][8:1]));
            chk("R2", "fast_read", 32'(fast_read_o), 32'(VEC[i][0]));
            chk("R9", "enh_func",  32'(enh_func_o),  32'(VEC[i][4]));
            chk("R9", "sync_skip", 32'(sync_skip_o), 32'(VEC[i][3]));
            chk("R9", "core_run kept", 32'(core_run_o), 32'd1);
        end
        bus_strap_i = 1'b1; bus_muxed_i = 1'b0;

        // R6: restart command while running changes nothing
        drive(1'b0, 8'h00, 1'b1, 8'h18);
        chk("R6", "core_run", 32'(core_run_o), 32'd1);
        chk("R6", "pll_en",   32'(pll_en_o),   32'd0);

        // R3: reserved select code is dropped
        drive(1'b1, 8'h20, 1'b0, 8'h00);
        chk("R3", "clk_sel",  32'(clk_sel_o),  32'd0);
        chk("R3", "core_run", 32'(core_run_o), 32'd1);
        chk("R3", "pll_en",   32'(pll_en_o),   32'd0);
        chk("R3", "sel_err",  32'(sel_err_o),  32'd0);

        // R8: rewriting the current select is no change and no error
        drive(1'b1, 8'h00, 1'b0, 8'h00);
        chk("R8", "sel_err same", 32'(sel_err_o), 32'd0);
        chk("R8", "core_run same", 32'(core_run_o), 32'd1);

        // R11 + R4: select change to 01 collides with a restart command
        drive(1'b1, 8'h10, 1'b1, 8'h18);
        chk("R4", "clk_sel",  32'(clk_sel_o),  32'd1);
        chk("R4", "core_run", 32'(core_run_o), 32'd0);
        chk("R4", "pll_en",   32'(pll_en_o),   32'd1);
        chk("R5", "lock_cnt start", 32'(lock_cnt_o), 32'd0);
        for (int j = 1; j < LOCK; j++) begin
            @(negedge clk);
            chk("R5", "lock_cnt", 32'(lock_cnt_o), 32'(j));
            chk("R5", "locked early", 32'(pll_locked_o), 32'd0);
        end
        @(negedge clk);
        chk("R5", "locked", 32'(pll_locked_o), 32'd1);
        repeat (3) @(negedge clk);
        chk("R5", "lock_cnt saturated", 32'(lock_cnt_o), 32'(LOCK));
        chk("R11", "core_run after lock", 32'(core_run_o), 32'd0);
        chk("R4", "pll_en held", 32'(pll_en_o), 32'd1);

        // R6: wrong command ignored, then 0x18 restarts
        drive(1'b0, 8'h00, 1'b1, 8'h55);
        chk("R6", "core_run wrong cmd", 32'(core_run_o), 32'd0);
        drive(1'b0, 8'h00, 1'b1, 8'h18);
        chk("R6", "core_run restart", 32'(core_run_o), 32'd1);

        // R8: second change refused, error sticky
        drive(1'b1, 8'h30, 1'b0, 8'h00);
        chk("R8", "clk_sel kept", 32'(clk_sel_o), 32'd1);
        chk("R8", "sel_err", 32'(sel_err_o), 32'd1);
        chk("R8", "core_run", 32'(core_run_o), 32'd1);
        drive(1'b1, 8'h10, 1'b0, 8'h00);
        chk("R8", "sel_err sticky", 32'(sel_err_o), 32'd1);

        // R1 again, then R7: early restart command
        do_reset();
        reset_checks();
        drive(1'b1, 8'h38, 1'b0, 8'h00);
        chk("R4", "clk_sel x4", 32'(clk_sel_o), 32'd3);
        chk("R9", "enh_func with change", 32'(enh_func_o), 32'd1);
        drive(1'b0, 8'h00, 1'b1, 8'h18);
        chk("R7", "core_run before lock", 32'(core_run_o), 32'd0);
        repeat (LOCK - 1) @(negedge clk);
        chk("R7", "locked", 32'(pll_locked_o), 32'd1);
        chk("R7", "core_run at lock", 32'(core_run_o), 32'd0);
        @(negedge clk);
        chk("R7", "core_run after lock", 32'(core_run_o), 32'd1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule